// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the base address registers of one bus function into decoded address windows. It serves six ordinary regions and one expansion ROM region. For each region it holds a base, an inclusive limit and a valid flag, and it raises a one-cycle remap pulse whenever that region's base moves, so that downstream address decode can be updated. The decision to map a region depends on several things: the I/O and memory enable bits of the command register, the ROM's own enable bit, the region's power-of-two size and its space type, and a set of sanity rules on the resulting range.

Evaluation is requested by a strobe. The strobe only takes effect when an ordinary BAR word or one of the two command enable bits differs from the values seen at the previous request. A change to the ROM word, a size or a type alone therefore waits for the next effective evaluation. A combinational hit check compares a probe address and space against the windows currently held.

Top module: `bar_window_decoder`

## Requirements
- R1: After synchronous reset every region is unmapped: valid 0, base and limit all ones, remap 0 and hit 0.
- R2: A mapped region's base is its register word ANDed with the inverse of (size − 1), and its limit is base + size − 1. An unmapped region shows all ones in both base and limit.
- R3: Regions whose type bit is 1 decode I/O space and need cmd_io_en. All other regions, including the ROM (index 6), decode memory space and need cmd_mem_en. A region of size zero is never mapped.
- R4: The ROM region is mapped only when bit 0 of rom_word is 1.
- R5: A region is unmapped when its masked base is zero, or when base + size − 1 does not exceed the base (so a size of 1 is never mapped).
- R6: An I/O region is unmapped when its limit is 0x10000 or above. A memory region is unmapped when its limit is 0xFFFFFFFF.
- R7: Windows are recomputed at the clock edge that samples eval_req high, and only when bar_word, cmd_io_en or cmd_mem_en differs from its value at the previous eval_req (all zero after reset). Changing only rom_word, rgn_size or rgn_is_io does not trigger a recompute.
- R8: At a recompute, remap[i] is high for exactly the following cycle, and only if region i's new base differs from the base it held before.
- R9: hit[i] is 1 when region i is valid, probe_io equals the region's space (1 = I/O), and base ≤ probe_addr ≤ limit. It uses the windows held before any recompute at the coming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_io_en | input | 1 | Command register I/O space enable |
| cmd_mem_en | input | 1 | Command register memory space enable |
| eval_req | input | 1 | Request to re-evaluate the windows |
| bar_word | input | NBAR*32 | Ordinary BAR words, region i at bits [32i+31:32i] |
| rom_word | input | 32 | Expansion ROM register word, bit 0 = ROM enable |
| rgn_size | input | NREG*32 | Power-of-two region sizes, ROM last |
| rgn_is_io | input | NBAR | Space type of ordinary regions, 1 = I/O |
| probe_addr | input | 32 | Address to test against the windows |
| probe_io | input | 1 | Space of the probe, 1 = I/O |
| win_base | output | NREG*32 | Held window bases |
| win_limit | output | NREG*32 | Held window limits |
| win_valid | output | NREG | Region mapped |
| remap | output | NREG | One-cycle pulse on a base change |
| hit | output | NREG | Probe falls in the region's window |

## Verification
The hit check and a recompute can land in the same cycle. A probe is driven together with an effective eval_req, and hit is sampled before that edge. It must match the windows the reference model held before the recompute, while base, limit, valid and remap are judged one edge later against the newly computed windows. Random register words (zero, low I/O-range values, top-of-space values, arbitrary values) are mixed with directed cases at the I/O ceiling, the all-ones memory limit, the ROM enable bit, the ROM-only write, and a same-base rewrite.

// File: rtl/bar_dec_pkg.sv
// Shared address type and decode constants for the BAR window decoder.
package bar_dec_pkg;
    localparam int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;
    localparam addr_t UNMAPPED      = '1;
    localparam addr_t IO_LIMIT_EXCL = addr_t'(32'h0001_0000);
endpackage

// File: rtl/bar_change_detect.sv
// Decides whether an evaluation request is effective.
// It remembers the ordinary BAR words and the two command enables as they were
// at the last request, and lets a request through only when one of them differs.
// Assumes: eval_req is a level sampled every cycle.
module bar_change_detect
    import bar_dec_pkg::*;
#(
    parameter int NBAR = 6,
    localparam int BW  = NBAR * ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_req,
    input  logic [BW-1:0] bar_word,
    input  logic          io_en,
    input  logic          mem_en,
    output logic          do_eval
);
    logic [BW-1:0] snap_bar;
    logic          snap_io;
    logic          snap_mem;
    logic          differs;

    // Compare the live inputs with the snapshot.
    always_comb begin
        differs = (bar_word != snap_bar) || (io_en != snap_io) || (mem_en != snap_mem);
        do_eval = eval_req && differs;
    end

    // Capture the inputs at every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_bar <= '0;
            snap_io  <= 1'b0;
            snap_mem <= 1'b0;
        end else if (eval_req) begin
            snap_bar <= bar_word;
            snap_io  <= io_en;
            snap_mem <= mem_en;
        end
    end

    // A repeated request on unchanged inputs must not re-evaluate (R7).
    p_repeat_is_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && $past(eval_req) && $past(rst_n) && $stable(bar_word)
         && $stable(io_en) && $stable(mem_en)) |-> !do_eval);
endmodule

// File: rtl/bar_region.sv
// Evaluates and holds one decoded window.
// On do_eval it applies the enable, ROM-bit, zero-base, wrap and ceiling rules
// to the masked register word, then stores base, limit, valid and space.
// Assumes: size is zero or a power of two.
module bar_region
    import bar_dec_pkg::*;
#(
    parameter bit IS_ROM = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  do_eval,
    input  addr_t word,
    input  addr_t size,
    input  logic  is_io,
    input  logic  io_en,
    input  logic  mem_en,
    output addr_t base_q,
    output addr_t limit_q,
    output logic  valid_q,
    output logic  space_io_q,
    output logic  remap_q
);
    addr_t mask;
    addr_t cand;
    addr_t last;
    logic  space_io;
    logic  enabled;
    logic  range_ok;
    logic  new_valid;
    addr_t new_base;
    addr_t new_limit;

    // Compute the candidate window and its validity.
    always_comb begin
        mask      = size - addr_t'(1);
        cand      = word & ~mask;
        last      = cand + mask;
        space_io  = IS_ROM ? 1'b0 : is_io;
        enabled   = space_io ? io_en : (mem_en && (!IS_ROM || word[0]));
        range_ok  = (cand != '0) && (last > cand)
                    && (space_io ? (last < IO_LIMIT_EXCL) : (last != UNMAPPED));
        new_valid = (size != '0) && enabled && range_ok;
        new_base  = new_valid ? cand : UNMAPPED;
        new_limit = new_valid ? last : UNMAPPED;
    end

    // Hold the window and flag a change of base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= UNMAPPED;
            limit_q    <= UNMAPPED;
            valid_q    <= 1'b0;
            space_io_q <= 1'b0;
            remap_q    <= 1'b0;
        end else begin
            remap_q <= 1'b0;
            if (do_eval) begin
                base_q     <= new_base;
                limit_q    <= new_limit;
                valid_q    <= new_valid;
                space_io_q <= space_io;
                remap_q    <= (new_base != base_q);
            end
        end
    end

    p_remap_means_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_q |-> (base_q != $past(base_q)));
    p_still_base_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!remap_q && $past(rst_n)) |-> $stable(base_q));
    p_window_sane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (base_q != '0 && limit_q > base_q));
    p_io_below_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && space_io_q) |-> (limit_q < IO_LIMIT_EXCL));
    p_mem_not_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !space_io_q) |-> (limit_q != UNMAPPED));
endmodule

// File: rtl/bar_window_hit.sv
// Combinational address match against every held window.
// Assumes: base and limit are meaningful only while valid is set.
module bar_window_hit
    import bar_dec_pkg::*;
#(
    parameter int NREG = 7,
    localparam int WW  = NREG * ADDR_W
) (
    input  addr_t           probe_addr,
    input  logic            probe_io,
    input  logic [WW-1:0]   base,
    input  logic [WW-1:0]   limit,
    input  logic [NREG-1:0] valid,
    input  logic [NREG-1:0] space_io,
    output logic [NREG-1:0] hit
);
    for (genvar r = 0; r < NREG; r++) begin : g_cmp
        addr_t lo;
        addr_t hi;
        // Range and space test for one region.
        always_comb begin
            lo     = base[r*ADDR_W +: ADDR_W];
            hi     = limit[r*ADDR_W +: ADDR_W];
            hit[r] = valid[r] && (space_io[r] == probe_io)
                     && (probe_addr >= lo) && (probe_addr <= hi);
        end
    end
endmodule

// File: rtl/bar_window_decoder.sv
// Top level: six ordinary regions plus the expansion ROM (last index).
// Shares one change detector across all regions, instantiates one evaluator
// per region, and exposes a combinational hit check on the held windows.
// Assumes: sizes are zero or powers of two; the ROM always decodes memory.
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int NBAR  = 6,
    localparam int NREG = NBAR + 1,
    localparam int BW   = NBAR * ADDR_W,
    localparam int WW   = NREG * ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_io_en,
    input  logic            cmd_mem_en,
    input  logic            eval_req,
    input  logic [BW-1:0]   bar_word,
    input  logic [31:0]     rom_word,
    input  logic [WW-1:0]   rgn_size,
    input  logic [NBAR-1:0] rgn_is_io,
    input  logic [31:0]     probe_addr,
    input  logic            probe_io,
    output logic [WW-1:0]   win_base,
    output logic [WW-1:0]   win_limit,
    output logic [NREG-1:0] win_valid,
    output logic [NREG-1:0] remap,
    output logic [NREG-1:0] hit
);
    logic            do_eval;
    logic [NREG-1:0] space_io;

    bar_change_detect #(.NBAR(NBAR)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval_req (eval_req),
        .bar_word (bar_word),
        .io_en    (cmd_io_en),
        .mem_en   (cmd_mem_en),
        .do_eval  (do_eval)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        addr_t word;
        logic  type_io;
        if (r < NBAR) begin : g_plain
            assign word    = bar_word[r*ADDR_W +: ADDR_W];
            assign type_io = rgn_is_io[r];
        end else begin : g_rom
            assign word    = rom_word;
            assign type_io = 1'b0;
        end
        bar_region #(.IS_ROM(r == NBAR)) u_rgn (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_eval    (do_eval),
            .word       (word),
            .size       (rgn_size[r*ADDR_W +: ADDR_W]),
            .is_io      (type_io),
            .io_en      (cmd_io_en),
            .mem_en     (cmd_mem_en),
            .base_q     (win_base[r*ADDR_W +: ADDR_W]),
            .limit_q    (win_limit[r*ADDR_W +: ADDR_W]),
            .valid_q    (win_valid[r]),
            .space_io_q (space_io[r]),
            .remap_q    (remap[r])
        );
    end

    bar_window_hit #(.NREG(NREG)) u_hit (
        .probe_addr (probe_addr),
        .probe_io   (probe_io),
        .base       (win_base),
        .limit      (win_limit),
        .valid      (win_valid),
        .space_io   (space_io),
        .hit        (hit)
    );

    // Without a request no region may report a remap (R7).
    p_no_req_no_remap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_req |=> (remap == '0));
endmodule

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
    localparam int NBAR = 6;
    localparam int NREG = NBAR + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_io_en = 1'b0, cmd_mem_en = 1'b0, eval_req = 1'b0;
    logic [NBAR*32-1:0] bar_flat;
    logic [31:0] rom_word = '0;
    logic [NREG*32-1:0] size_flat;
    logic [NBAR-1:0] rtype = '0;
    logic [31:0] probe_addr = '0;
    logic probe_io = 1'b0;
    logic [NREG*32-1:0] win_base, win_limit;
    logic [NREG-1:0] win_valid, remap, hit;

    logic [31:0] bw [NBAR];
    logic [31:0] sz [NREG];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_base [NREG];
    logic [31:0] m_limit [NREG];
    bit m_valid [NREG];
    bit m_io [NREG];
    logic [NBAR*32-1:0] s_bar = '0;
    bit s_io = 0, s_mem = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NBAR; i++) bar_flat[i*32 +: 32] = bw[i];
        for (int i = 0; i < NREG; i++) size_flat[i*32 +: 32] = sz[i];
    end

    bar_window_decoder #(.NBAR(NBAR)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .eval_req(eval_req), .bar_word(bar_flat), .rom_word(rom_word),
        .rgn_size(size_flat), .rgn_is_io(rtype), .probe_addr(probe_addr),
        .probe_io(probe_io), .win_base(win_base), .win_limit(win_limit),
        .win_valid(win_valid), .remap(remap), .hit(hit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference window computed from the requirements.
    task automatic model_rgn(input int r, output logic [31:0] b, output logic [31:0] l,
                             output bit v, output bit io);
        logic [31:0] w;
        logic [31:0] s;
        logic [31:0] cand;
        logic [32:0] last;
        w = (r == NBAR) ? rom_word : bw[r];
        s = sz[r];
        io = (r == NBAR) ? 1'b0 : rtype[r];
        cand = w & ~(s - 32'd1);
        last = {1'b0, cand} + {1'b0, s} - 33'd1;
        v = (s != 0);
        if (io) v = v && cmd_io_en;
        else    v = v && cmd_mem_en && ((r != NBAR) || w[0]);
        if (cand == 0 || s == 1 || last[32]) v = 0;
        if (io && last >= 33'h1_0000) v = 0;
        if (!io && last[31:0] == 32'hFFFF_FFFF) v = 0;
        b = v ? cand : 32'hFFFF_FFFF;
        l = v ? last[31:0] : 32'hFFFF_FFFF;
    endtask

    task automatic check_hits();
        for (int r = 0; r < NREG; r++) begin
            bit e;
            e = m_valid[r] && (m_io[r] == probe_io) && probe_addr >= m_base[r] && probe_addr <= m_limit[r];
            check(hit[r] == e, $sformatf("R9 hit[%0d]", r), 32'(hit[r]), 32'(e));
        end
    endtask

    // Inputs are set at a negedge; hits checked before the edge, windows after.
    task automatic step(input bit req);
        bit trig;
        logic [31:0] eb [NREG];
        logic [31:0] el [NREG];
        bit ev [NREG];
        bit eio [NREG];
        eval_req = req;
        #1;
        check_hits();
        trig = req && (bar_flat != s_bar || cmd_io_en != s_io || cmd_mem_en != s_mem);
        for (int r = 0; r < NREG; r++) model_rgn(r, eb[r], el[r], ev[r], eio[r]);
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < NREG; r++) begin
            bit er;
            er = trig && (eb[r] != m_base[r]);
            check(remap[r] == er, $sformatf("R8 remap[%0d]", r), 32'(remap[r]), 32'(er));
            if (trig) begin
                m_base[r] = eb[r]; m_limit[r] = el[r]; m_valid[r] = ev[r]; m_io[r] = eio[r];
            end
            check(win_base[r*32 +: 32] == m_base[r], $sformatf("R2 base[%0d]", r), win_base[r*32 +: 32], m_base[r]);
            check(win_limit[r*32 +: 32] == m_limit[r], $sformatf("R2 limit[%0d]", r), win_limit[r*32 +: 32], m_limit[r]);
            check(win_valid[r] == m_valid[r], $sformatf("R7 valid[%0d]", r), 32'(win_valid[r]), 32'(m_valid[r]));
        end
        if (req) begin s_bar = bar_flat; s_io = cmd_io_en; s_mem = cmd_mem_en; end
        eval_req = 0;
    endtask

    function automatic logic [31:0] rand_word();
        case ($urandom % 4)
            0: return 32'h0;
            1: return $urandom & 32'h0000_FFFF;
            2: return 32'hFFFF_F000 | ($urandom & 32'hFFF);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NBAR; i++) bw[i] = '0;
        for (int i = 0; i < NREG; i++) begin
            sz[i] = '0; m_base[i] = '1; m_limit[i] = '1; m_valid[i] = 0; m_io[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(win_valid == '0, "R1 valid", 32'(win_valid), 32'h0);
        check(win_base == '1, "R1 base", win_base[31:0], 32'hFFFF_FFFF);
        check(win_limit == '1, "R1 limit", win_limit[31:0], 32'hFFFF_FFFF);
        check(remap == '0, "R1 remap", 32'(remap), 32'h0);
        check(hit == '0, "R1 hit", 32'(hit), 32'h0);

        // Directed: I/O at the ceiling, memory at the top, ROM enabled
        sz[0] = 32'h100; rtype[0] = 1'b1; sz[1] = 32'h1000; sz[NBAR] = 32'h800;
        bw[0] = 32'h0000_FF00; bw[1] = 32'hFFFF_F000; rom_word = 32'h000C_0001;
        cmd_io_en = 1; cmd_mem_en = 1; probe_addr = 32'hFF80; probe_io = 1;
        step(1);
        check(win_valid[0] && win_limit[31:0] == 32'hFFFF, "R6 io limit FFFF ok", win_limit[31:0], 32'hFFFF);
        check(!win_valid[1], "R6 mem limit all ones", 32'(win_valid[1]), 32'h0);
        check(win_valid[NBAR] && win_base[NBAR*32 +: 32] == 32'h000C_0000, "R4 rom on",
              win_base[NBAR*32 +: 32], 32'h000C_0000);
        #1;
        check(hit[0] == 1'b1, "R9 io probe hit", 32'(hit[0]), 32'h1);
        probe_io = 0; #1;
        check(hit[0] == 1'b0, "R9 wrong space", 32'(hit[0]), 32'h0);

        bw[0] = 32'h0001_0000; step(1);
        check(!win_valid[0], "R6 io at 0x10000", 32'(win_valid[0]), 32'h0);

        rom_word = 32'h000C_0000; step(1);
        check(win_valid[NBAR] == 1'b1, "R7 rom-only write ignored", 32'(win_valid[NBAR]), 32'h1);

        cmd_mem_en = 0; step(1);
        check(!win_valid[NBAR], "R3 mem disabled", 32'(win_valid[NBAR]), 32'h0);
        cmd_mem_en = 1; step(1);
        check(!win_valid[NBAR], "R4 rom bit clear", 32'(win_valid[NBAR]), 32'h0);

        bw[1] = 32'h1234_5678; step(1);
        bw[1] = 32'h1234_5ABC; step(1);
        check(!remap[1] && win_base[63:32] == 32'h1234_5000, "R8 same base no remap",
              win_base[63:32], 32'h1234_5000);

        bw[1] = 32'h0000_0FFF; step(1);
        check(!win_valid[1], "R5 zero base", 32'(win_valid[1]), 32'h0);

        sz[2] = 32'h1; bw[2] = 32'h4000; step(1);
        check(!win_valid[2], "R5 size one", 32'(win_valid[2]), 32'h0);

        bw[0] = 32'h2000; bw[3] = 32'h8000; step(1);
        check(win_valid[0] && !win_valid[3], "R3 io on, size zero off", 32'(win_valid[3]), 32'h0);
        cmd_io_en = 0; step(1);
        check(!win_valid[0], "R3 io disabled", 32'(win_valid[0]), 32'h0);

        // Random phase
        for (int i = 0; i < NREG; i++)
            sz[i] = ($urandom % 6 == 0) ? 32'h0 : (32'h1 << (2 + $urandom % 15));
        for (int i = 0; i < NBAR; i++) rtype[i] = $urandom % 2;
        for (int it = 0; it < 400; it++) begin
            int r;
            for (int i = 0; i < NBAR; i++) if ($urandom % 2) bw[i] = rand_word();
            if ($urandom % 3 == 0) rom_word = rand_word();
            if ($urandom % 4 == 0) cmd_io_en = $urandom % 2;
            if ($urandom % 4 == 0) cmd_mem_en = $urandom % 2;
            r = $urandom % NREG;
            probe_io = m_io[r];
            case ($urandom % 4)
                0: probe_addr = m_base[r] + ($urandom & (sz[r] - 32'd1));
                1: probe_addr = m_base[r] - 32'd1;
                2: probe_addr = m_limit[r] + 32'd1;
                default: probe_addr = m_limit[r];
            endcase
            step($urandom % 4 != 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule